// File: doc/BRIEF.md
# Predication Key-Value Lookup Table

This block keeps a small associative table that tells instruction decode whether an operation's destination register is predicated and, if so, which integer register supplies the element mask. Each of the sixteen table entries is a key-value pair. The key names a destination register and whether it lives in the integer or the floating-point file. The value names the integer register whose bits, indexed by element number, enable or suppress each element.

Software fills the table through a write port and can read back any entry to save and restore it. Scanning sixteen keys on every decode would put a comparator tree in the decode path. The block therefore flattens the table into direct lookup state whenever the table changes: one enable flag and one five-bit mask index per register, held separately for the 32 integer and the 32 floating-point registers. Decode presents a destination index and a type and gets the answer combinationally from those arrays. Reading the mask register itself and applying it to elements happen elsewhere.

Top module: `pred_kv_table`

## Requirements
- R1: After reset every entry reads back as zero and no query, integer or floating-point, reports predication.
- R2: A write to entry `wrAddr` stores the 12-bit `wrData`. From the next cycle, `rdData` returns that value combinationally when `rdAddr` selects the entry.
- R3: Entry layout: bit 11 is the enable, bit 10 is the type (0 = integer, 1 = floating-point), bits 9..5 are the predicated register and bits 4..0 are the mask register. An enabled integer entry makes a query with `qryIsFp`=0 and `qryIdx` equal to bits 9..5 report `qryPred`=1 and `qryMaskIdx` equal to bits 4..0.
- R4: Integer and floating-point keys are separate. An entry with bit 10 set affects only queries with `qryIsFp`=1, and an entry with bit 10 clear affects only queries with `qryIsFp`=0, even for the same register index.
- R5: An entry whose bit 11 is clear has no effect on any query, whatever its other bits hold.
- R6: When several enabled entries carry the same register and type, the entry with the highest number supplies the mask index.
- R7: A query in the cycle a write is presented sees the mapping from before that write, and a read of the entry being written returns its old contents. From the next cycle on, queries see the mapping built from the updated table.
- R8: `qryMaskIdx` is zero whenever `qryPred` is zero.
- R9: Overwriting or disabling an entry removes every effect it had. A key it used to win falls back to the next highest remaining enabled entry, or to unpredicated if none remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the table |
| wrAddr | input | 4 | Entry number being written |
| wrData | input | 12 | New entry contents |
| rdAddr | input | 4 | Entry number to read back |
| rdData | output | 12 | Contents of the selected entry |
| qryIdx | input | 5 | Destination register index from decode |
| qryIsFp | input | 1 | 1 selects the floating-point lookup, 0 the integer lookup |
| qryPred | output | 1 | The destination is predicated |
| qryMaskIdx | output | 5 | Integer register holding the mask |

## Verification
A table write and a decode query can arrive in the same cycle, and so can a write and a read-back of the entry being written. The bench provokes both on every write. While the write strobe is high, it queries the key carried by the new data and reads the target entry. It expects the old mapping and the old contents, both computed from its own copy of the table. After the clock edge it repeats the query and expects the new mapping. A full sweep of all 64 register/type queries and all 16 read-backs then follows each write, so collisions between keys, including wins by the higher entry and fall-back after a disable, are judged against a sequential scan done in the bench.

// File: rtl/pkv_pkg.sv
`timescale 1ns/1ps
package pkv_pkg;
  localparam int REG_IDX_W = 5;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam int ENTRY_W   = 2 + 2 * REG_IDX_W;

  typedef struct packed {
    logic                 en;
    logic                 isFp;
    logic [REG_IDX_W-1:0] key;
    logic [REG_IDX_W-1:0] mask;
  } entry_t;

  localparam int NUM_KINDS = 2;
  localparam logic KIND_INT = 1'b0;
  localparam logic KIND_FP  = 1'b1;
endpackage

// File: rtl/pkv_ctrl.sv
`timescale 1ns/1ps
module pkv_ctrl #(
  parameter int NUM_ENTRIES = 16,
  localparam int ENT_W = $clog2(NUM_ENTRIES)
) (
  input  logic             wrEn,
  input  logic [ENT_W-1:0] wrAddr,
  output logic [NUM_ENTRIES-1:0] loadStb,
  output logic             rebuildStb
);
  genvar gE;
  generate
    for (gE = 0; gE < NUM_ENTRIES; gE++) begin : g_dec
      assign loadStb[gE] = wrEn && (wrAddr == ENT_W'(gE));
    end
  endgenerate

  assign rebuildStb = wrEn;
endmodule

// File: rtl/pkv_flatten.sv
`timescale 1ns/1ps
module pkv_flatten
  import pkv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter logic KIND = KIND_INT
) (
  input  entry_t               entries [NUM_ENTRIES],
  output logic [NUM_REGS-1:0]  regEn,
  output logic [REG_IDX_W-1:0] regMask [NUM_REGS]
);
  genvar gR;
  generate
    for (gR = 0; gR < NUM_REGS; gR++) begin : g_reg
      always_comb begin
        regEn[gR]   = 1'b0;
        regMask[gR] = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (entries[e].en && (entries[e].isFp == KIND) &&
              (entries[e].key == REG_IDX_W'(gR))) begin
            regEn[gR]   = 1'b1;
            regMask[gR] = entries[e].mask;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pkv_dpath.sv
`timescale 1ns/1ps
module pkv_dpath
  import pkv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int ENT_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ENTRIES-1:0] loadStb,
  input  logic                   rebuildStb,
  input  logic [ENTRY_W-1:0]     wrData,
  input  logic [ENT_W-1:0]       rdAddr,
  output logic [ENTRY_W-1:0]     rdData,
  input  logic [REG_IDX_W-1:0]   qryIdx,
  input  logic                   qryIsFp,
  output logic                   qryPred,
  output logic [REG_IDX_W-1:0]   qryMaskIdx
);
  entry_t tableQ    [NUM_ENTRIES];
  entry_t tableNext [NUM_ENTRIES];

  logic [NUM_REGS-1:0]  enNext   [NUM_KINDS];
  logic [REG_IDX_W-1:0] maskNext [NUM_KINDS][NUM_REGS];
  logic [NUM_REGS-1:0]  enQ      [NUM_KINDS];
  logic [REG_IDX_W-1:0] maskQ    [NUM_KINDS][NUM_REGS];

  genvar gE, gK, gR;
  generate
    for (gE = 0; gE < NUM_ENTRIES; gE++) begin : g_ent
      assign tableNext[gE] = loadStb[gE] ? entry_t'(wrData) : tableQ[gE];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) tableQ[gE] <= '0;
        else if (loadStb[gE]) tableQ[gE] <= entry_t'(wrData);
      end
    end

    for (gK = 0; gK < NUM_KINDS; gK++) begin : g_kind
      pkv_flatten #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .KIND(gK[0])
      ) u_flat (
        .entries(tableNext),
        .regEn  (enNext[gK]),
        .regMask(maskNext[gK])
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) enQ[gK] <= '0;
        else if (rebuildStb) enQ[gK] <= enNext[gK];
      end

      for (gR = 0; gR < NUM_REGS; gR++) begin : g_mreg
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) maskQ[gK][gR] <= '0;
          else if (rebuildStb) maskQ[gK][gR] <= maskNext[gK][gR];
        end
      end
    end
  endgenerate

  assign rdData = ENTRY_W'(tableQ[rdAddr]);

  logic kindSel;
  assign kindSel    = qryIsFp;
  assign qryPred    = enQ[kindSel][qryIdx];
  assign qryMaskIdx = qryPred ? maskQ[kindSel][qryIdx] : '0;
endmodule

// File: rtl/pred_kv_table.sv
`timescale 1ns/1ps
module pred_kv_table
  import pkv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int ENT_W = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ENT_W-1:0]     wrAddr,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic [ENT_W-1:0]     rdAddr,
  output logic [ENTRY_W-1:0]   rdData,
  input  logic [REG_IDX_W-1:0] qryIdx,
  input  logic                 qryIsFp,
  output logic                 qryPred,
  output logic [REG_IDX_W-1:0] qryMaskIdx
);
  typedef struct packed {
    logic [NUM_ENTRIES-1:0] load;
    logic                   rebuild;
  } strobe_t;

  strobe_t stb;

  pkv_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .loadStb   (stb.load),
    .rebuildStb(stb.rebuild)
  );

  pkv_dpath #(.NUM_ENTRIES(NUM_ENTRIES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .loadStb   (stb.load),
    .rebuildStb(stb.rebuild),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .qryIdx    (qryIdx),
    .qryIsFp   (qryIsFp),
    .qryPred   (qryPred),
    .qryMaskIdx(qryMaskIdx)
  );
endmodule

// File: rtl/pkv_checker.sv
`timescale 1ns/1ps
module pkv_checker
  import pkv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int ENT_W = $clog2(NUM_ENTRIES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ENT_W-1:0]     wrAddr,
  input logic [ENTRY_W-1:0]   wrData,
  input logic [ENT_W-1:0]     rdAddr,
  input logic [ENTRY_W-1:0]   rdData,
  input logic [REG_IDX_W-1:0] qryIdx,
  input logic                 qryIsFp,
  input logic                 qryPred,
  input logic [REG_IDX_W-1:0] qryMaskIdx
);
  p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !qryPred |-> (qryMaskIdx == '0));

  p_map_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn) && $stable(qryIdx) && $stable(qryIsFp))
      |-> ($stable(qryPred) && $stable(qryMaskIdx)));

  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && (rdAddr == $past(wrAddr)))
      |-> (rdData == $past(wrData)));

  p_rd_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn) && $stable(rdAddr)) |-> $stable(rdData));
endmodule

bind pred_kv_table pkv_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .qryIdx(qryIdx), .qryIsFp(qryIsFp),
  .qryPred(qryPred), .qryMaskIdx(qryMaskIdx)
);

// File: tb/sim_pred_kv_table.sv
`timescale 1ns/1ps
module sim_pred_kv_table;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [11:0] rdData;
  logic [4:0]  qryIdx = '0;
  logic        qryIsFp = 1'b0;
  logic        qryPred;
  logic [4:0]  qryMaskIdx;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;
  logic [11:0] shadow [16];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  pred_kv_table u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .qryIdx(qryIdx), .qryIsFp(qryIsFp),
    .qryPred(qryPred), .qryMaskIdx(qryMaskIdx)
  );

  // sequential scan from entry 0 upward; the last match stands
  task automatic model(input logic [4:0] idx, input logic isFp,
                       output logic pred, output logic [4:0] msk);
    pred = 1'b0;
    msk  = '0;
    for (int e = 0; e < 16; e++) begin
      if (shadow[e][11] && shadow[e][10] == isFp && shadow[e][9:5] == idx) begin
        pred = 1'b1;
        msk  = shadow[e][4:0];
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkQuery(input string tag, input logic [4:0] idx,
                            input logic isFp);
    logic ep;
    logic [4:0] em;
    qryIdx  = idx;
    qryIsFp = isFp;
    #1;
    model(idx, isFp, ep, em);
    check(tag, {31'd0, qryPred}, {31'd0, ep},
          $sformatf("pred reg %0d fp %0d", idx, isFp));
    check(tag, {27'd0, qryMaskIdx}, {27'd0, em},
          $sformatf("mask reg %0d fp %0d", idx, isFp));
  endtask

  task automatic sweep(input string tag);
    for (int e = 0; e < 16; e++) begin
      rdAddr = 4'(e);
      #1;
      check("R2", {20'd0, rdData}, {20'd0, shadow[e]},
            $sformatf("readback entry %0d", e));
    end
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 32; r++)
        checkQuery(tag, 5'(r), t[0]);
  endtask

  task automatic writeEntry(input logic [3:0] a, input logic [11:0] d,
                            input string tag);
    @(negedge clk);
    wrEn = 1'b1;
    wrAddr = a;
    wrData = d;
    rdAddr = a;
    // R7: same-cycle query and read see the old state
    checkQuery("R7", d[9:5], d[10]);
    check("R7", {20'd0, rdData}, {20'd0, shadow[a]}, "read during write");
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    shadow[a] = d;
    checkQuery("R7", d[9:5], d[10]);
    sweep(tag);
  endtask

  initial begin
    for (int e = 0; e < 16; e++) shadow[e] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1");

    writeEntry(4'd0,  {1'b1, 1'b0, 5'd5,  5'd7},  "R3");
    writeEntry(4'd1,  {1'b1, 1'b1, 5'd5,  5'd9},  "R4");
    writeEntry(4'd2,  {1'b0, 1'b0, 5'd6,  5'd3},  "R5");
    writeEntry(4'd3,  {1'b1, 1'b0, 5'd5,  5'd12}, "R6");
    writeEntry(4'd15, {1'b1, 1'b1, 5'd31, 5'd1},  "R6");
    writeEntry(4'd10, {1'b1, 1'b1, 5'd31, 5'd31}, "R6");
    writeEntry(4'd4,  {1'b1, 1'b0, 5'd5,  5'd20}, "R6");
    writeEntry(4'd4,  {1'b0, 1'b0, 5'd5,  5'd20}, "R9");
    writeEntry(4'd3,  {1'b1, 1'b1, 5'd0,  5'd2},  "R9");
    writeEntry(4'd15, 12'h000,                    "R9");
    writeEntry(4'd7,  {1'b1, 1'b0, 5'd0,  5'd0},  "R8");

    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      writeEntry(lfsr[15:12], {lfsr[11] | lfsr[0], lfsr[10:0]}, "R6");
    end
    for (int e = 0; e < 16; e += 3)
      writeEntry(4'(e), {1'b0, shadow[e][10:0]}, "R9");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule